// File: doc/BRIEF.md
# Dual-Loop Out-of-Lock Detector

This block watches the phase comparators of two phase-locked loops and reports whether each loop has lost lock. For every loop it measures how long the comparator's up or down pulse stays high, in cycles of a fast sampling clock. A loop is declared out of lock as soon as one such pulse is wider than a programmable window. The flag is then held until a whole reference period passes with no pulse wider than the window. A loop that is powered down is treated as locked, so it never holds the flag.

Both loop states feed a shared active-low indicator pin. A select field decides whether the pin follows loop A, loop B, or either loop. With detection switched off, the same pin becomes a plain port output driven by a software bit. Each loop's tracker is a three-state machine:
- `LS_LOCKED`
- `LS_UNLOCKED`
- `LS_PWRDN`

It has five transitions:
- LOCKED→UNLOCKED when a run of active comparator cycles exceeds the window.
- UNLOCKED→LOCKED at a reference strobe that closes a period with no such run.
- LOCKED→PWRDN and UNLOCKED→PWRDN when power-down is asserted.
- PWRDN→LOCKED when power-down is released.

Top module: `lockdet_dual`

## Requirements
- R1: After reset both loop flags read 0 and `pin_n` reads 1.
- R2: The phase error of a loop is a run of consecutive sampling cycles in which its up or down input is high. A run longer than `ERR_LIMIT` cycles sets that loop's flag in the cycle after the (`ERR_LIMIT`+1)-th active cycle. A run of exactly `ERR_LIMIT` cycles, or two shorter runs split by one idle cycle, leaves the flag clear.
- R3: A set flag clears only at a reference strobe that closes a reference period with no run longer than `ERR_LIMIT`. The period in which the flag was set never counts as such a period. Runs of `ERR_LIMIT` cycles or fewer do not block clearing.
- R4: `sel` encoding: 0 means the pin follows loop A, 1 means it follows loop B, and 2 or 3 means it reports out-of-lock when either loop is out of lock.
- R5: With `det_en`=1, `pin_n` is 0 exactly when the selected status is out of lock, and 1 otherwise.
- R6: With `det_en`=0, `pin_n` equals `port_bit`, whatever the loop states are. The per-loop flags keep being reported.
- R7: While a loop's power-down input is 1, its flag reads 0 and comparator pulses are ignored. After release, the loop starts in the locked state.
- R8: A comparator pulse held high across reference strobes keeps the flag set. The flag clears only after the pulse ends and a later full period passes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_a | input | 1 | Loop A comparator up pulse |
| dn_a | input | 1 | Loop A comparator down pulse |
| ref_a | input | 1 | Loop A reference-period strobe, one cycle |
| pd_a | input | 1 | Loop A power-down |
| up_b | input | 1 | Loop B comparator up pulse |
| dn_b | input | 1 | Loop B comparator down pulse |
| ref_b | input | 1 | Loop B reference-period strobe, one cycle |
| pd_b | input | 1 | Loop B power-down |
| det_en | input | 1 | 1: pin shows lock status; 0: pin is a port |
| sel | input | 2 | Status select (see R4) |
| port_bit | input | 1 | Pin value when detection is disabled |
| pin_n | output | 1 | Pin level, 0 means transistor on / pulled low |
| ool_a | output | 1 | Loop A out-of-lock flag |
| ool_b | output | 1 | Loop B out-of-lock flag |

## Verification
The assertions assume a few things about the inputs:
- Comparator pulses and reference strobes are synchronous to the sampling clock.
- A reference strobe lasts a single cycle.
- Control inputs change only between clock edges.

The bench drives every input on the falling edge and keeps each strobe exactly one cycle wide. It only changes `sel`, `det_en` and the power-down bits while the loops are idle. This way a flag transition can always be traced back to a single wide run or a single strobe.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    typedef enum logic [1:0] {
        LS_LOCKED   = 2'd0,
        LS_UNLOCKED = 2'd1,
        LS_PWRDN    = 2'd2
    } lock_state_t;

    typedef enum logic [1:0] {
        SEL_LOOP_A = 2'd0,
        SEL_LOOP_B = 2'd1,
        SEL_ANY    = 2'd2,
        SEL_ANY_X  = 2'd3
    } pin_sel_t;

    localparam int NUM_LOOPS = 2;

endpackage

// File: rtl/lockdet_loop.sv
module lockdet_loop
    import lockdet_pkg::*;
#(
    parameter int ERR_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    input  logic ref_i,
    input  logic pd_i,
    output logic ool_o
);

    localparam int CW = $clog2(ERR_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(ERR_LIMIT);

    logic          act;
    logic          wide_now;
    logic [CW-1:0] run_q;
    logic          seen_q;
    lock_state_t   state_q, state_d;

    assign act      = up_i | dn_i;
    assign wide_now = act && (run_q == LIMIT_C);

    // run length of preceding active cycles, saturating at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (pd_i || !act) begin
            run_q <= '0;
        end else if (run_q != LIMIT_C) begin
            run_q <= run_q + 1'b1;
        end
    end

    // wide error seen in the current reference period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (pd_i) begin
            seen_q <= 1'b0;
        end else if (ref_i) begin
            seen_q <= wide_now;
        end else begin
            seen_q <= seen_q | wide_now;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_LOCKED: begin
                if (pd_i)          state_d = LS_PWRDN;
                else if (wide_now) state_d = LS_UNLOCKED;
            end
            LS_UNLOCKED: begin
                if (pd_i)                                state_d = LS_PWRDN;
                else if (ref_i && !seen_q && !wide_now)  state_d = LS_LOCKED;
            end
            LS_PWRDN: begin
                if (!pd_i) state_d = LS_LOCKED;
            end
            default: state_d = LS_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        ool_o = (state_q == LS_UNLOCKED);
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT_C)
        else $error("run counter above limit");

    p_set_needs_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ool_o) |-> $past(wide_now))
        else $error("flag set without a wide run");

    p_clear_at_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ool_o) |-> ($past(ref_i) || $past(pd_i)))
        else $error("flag cleared away from a strobe");

    p_pd_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_i |=> !ool_o)
        else $error("powered-down loop flagged");

endmodule

// File: rtl/lockdet_pinmux.sv
module lockdet_pinmux
    import lockdet_pkg::*;
(
    input  logic [NUM_LOOPS-1:0] ool_i,
    input  logic [1:0]           sel_i,
    input  logic                 det_en_i,
    input  logic                 port_bit_i,
    output logic                 pin_n_o
);

    logic flagged;

    always_comb begin
        unique case (pin_sel_t'(sel_i))
            SEL_LOOP_A: flagged = ool_i[0];
            SEL_LOOP_B: flagged = ool_i[1];
            SEL_ANY,
            SEL_ANY_X:  flagged = |ool_i;
            default:    flagged = |ool_i;
        endcase
        pin_n_o = det_en_i ? ~flagged : port_bit_i;
    end

endmodule

// File: rtl/lockdet_dual.sv
module lockdet_dual
    import lockdet_pkg::*;
#(
    parameter int ERR_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_a,
    input  logic       dn_a,
    input  logic       ref_a,
    input  logic       pd_a,
    input  logic       up_b,
    input  logic       dn_b,
    input  logic       ref_b,
    input  logic       pd_b,
    input  logic       det_en,
    input  logic [1:0] sel,
    input  logic       port_bit,
    output logic       pin_n,
    output logic       ool_a,
    output logic       ool_b
);

    logic [NUM_LOOPS-1:0] up_v, dn_v, ref_v, pd_v, ool_v;

    assign up_v  = {up_b, up_a};
    assign dn_v  = {dn_b, dn_a};
    assign ref_v = {ref_b, ref_a};
    assign pd_v  = {pd_b, pd_a};

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        lockdet_loop #(.ERR_LIMIT(ERR_LIMIT)) u_loop (
            .clk   (clk),
            .rst_n (rst_n),
            .up_i  (up_v[g]),
            .dn_i  (dn_v[g]),
            .ref_i (ref_v[g]),
            .pd_i  (pd_v[g]),
            .ool_o (ool_v[g])
        );
    end

    lockdet_pinmux u_mux (
        .ool_i      (ool_v),
        .sel_i      (sel),
        .det_en_i   (det_en),
        .port_bit_i (port_bit),
        .pin_n_o    (pin_n)
    );

    assign ool_a = ool_v[0];
    assign ool_b = ool_v[1];

    p_low_means_ool_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && !pin_n) |-> (ool_a || ool_b))
        else $error("pin low with both loops locked");

    p_sel_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && sel == 2'd0) |-> (pin_n == !ool_a))
        else $error("pin does not follow loop A");

    p_sel_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && sel == 2'd1) |-> (pin_n == !ool_b))
        else $error("pin does not follow loop B");

endmodule

// File: tb/tb_lockdet_dual.sv
module tb_lockdet_dual;

    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_a = 0, dn_a = 0, ref_a = 0, pd_a = 0;
    logic up_b = 0, dn_b = 0, ref_b = 0, pd_b = 0;
    logic det_en = 1'b1;
    logic [1:0] sel = 2'd2;
    logic port_bit = 1'b0;
    logic pin_n, ool_a, ool_b;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    lockdet_dual #(.ERR_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n),
        .up_a(up_a), .dn_a(dn_a), .ref_a(ref_a), .pd_a(pd_a),
        .up_b(up_b), .dn_b(dn_b), .ref_b(ref_b), .pd_b(pd_b),
        .det_en(det_en), .sel(sel), .port_bit(port_bit),
        .pin_n(pin_n), .ool_a(ool_a), .ool_b(ool_b)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // loop 0/1, use_dn selects the down line, w active cycles
    task automatic pulse(input int lp, input bit use_dn, input int w);
        if (lp == 0) begin if (use_dn) dn_a = 1; else up_a = 1; end
        else         begin if (use_dn) dn_b = 1; else up_b = 1; end
        repeat (w) @(negedge clk);
        up_a = 0; dn_a = 0; up_b = 0; dn_b = 0;
        idle(2);
    endtask

    task automatic strobe();
        ref_a = 1; ref_b = 1;
        @(negedge clk);
        ref_a = 0; ref_b = 0;
        idle(1);
    endtask

    task automatic t_reset();
        check("R1 ool_a", ool_a, 1'b0);
        check("R1 ool_b", ool_b, 1'b0);
        check("R1 pin_n", pin_n, 1'b1);
    endtask

    task automatic t_threshold();
        pulse(0, 0, LIM);
        check("R2 width at limit", ool_a, 1'b0);
        pulse(0, 0, LIM + 1);
        check("R2 width above limit", ool_a, 1'b1);
        check("R5 pin low on ool", pin_n, 1'b0);
    endtask

    task automatic t_clear();
        strobe();
        check("R3 hold through raising period", ool_a, 1'b1);
        strobe();
        check("R3 clear after clean period", ool_a, 1'b0);
        check("R5 pin released", pin_n, 1'b1);
    endtask

    task automatic t_small_ok();
        pulse(0, 0, LIM + 2);
        strobe();
        pulse(0, 0, LIM - 1);
        strobe();
        check("R3 short runs do not block clear", ool_a, 1'b0);
    endtask

    task automatic t_rewide();
        pulse(0, 0, LIM + 1);
        strobe();
        pulse(0, 1, LIM + 1);
        strobe();
        check("R3 wide down pulse blocks clear", ool_a, 1'b1);
        strobe();
        check("R3 clear after next clean period", ool_a, 1'b0);
    endtask

    task automatic t_gap();
        up_a = 1; idle(LIM); up_a = 0; idle(1);
        up_a = 1; idle(LIM); up_a = 0; idle(2);
        check("R2 split runs stay locked", ool_a, 1'b0);
    endtask

    task automatic t_long();
        up_a = 1;
        idle(LIM + 3);
        strobe();
        strobe();
        check("R8 held pulse keeps flag", ool_a, 1'b1);
        up_a = 0;
        idle(1);
        strobe();
        strobe();
        check("R8 clears after pulse ends", ool_a, 1'b0);
    endtask

    task automatic t_select();
        pulse(1, 1, LIM + 1);
        check("R2 loop B flag", ool_b, 1'b1);
        sel = 2'd0; idle(1);
        check("R4 sel A ignores B", pin_n, 1'b1);
        sel = 2'd1; idle(1);
        check("R4 sel B", pin_n, 1'b0);
        sel = 2'd3; idle(1);
        check("R4 sel either", pin_n, 1'b0);
        sel = 2'd2; idle(1);
    endtask

    task automatic t_port();
        det_en = 0; port_bit = 1; idle(1);
        check("R6 port high despite ool", pin_n, 1'b1);
        port_bit = 0; idle(1);
        check("R6 port low", pin_n, 1'b0);
        check("R6 flag still reported", ool_b, 1'b1);
        port_bit = 1; idle(1);
        check("R6 port back high", pin_n, 1'b1);
        det_en = 1; idle(1);
        check("R5 detection resumes", pin_n, 1'b0);
    endtask

    task automatic t_pwrdn();
        pd_b = 1; idle(2);
        check("R7 powered-down flag clear", ool_b, 1'b0);
        pulse(1, 0, LIM + 4);
        check("R7 pulses ignored in power-down", ool_b, 1'b0);
        pd_b = 0; idle(2);
        check("R7 starts locked", ool_b, 1'b0);
        check("R7 pin released", pin_n, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_threshold();
        t_clear();
        t_small_ok();
        t_rewide();
        t_gap();
        t_long();
        t_select();
        t_port();
        t_pwrdn();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule